// File: doc/BRIEF.md
# Rail Enable Sequencer with Timeout

This block drives the enable of one power rail. A level request input says which way the rail should go. Every change of that level opens a sequencing step in the new direction. The step holds off the enable change until a set of logical output states, picked by a per-direction mask, permit it. A per-direction time code sets a deadline that runs in parallel with the step. When the deadline passes before the conditions are met, a timeout flag is latched and the enable keeps its old value.

A debug input turns off the dependency check. The rail then switches when the deadline expires, and switches at once when the deadline is zero. Time is counted in millisecond ticks from an external strobe. A time code holds a two-bit increment selector above a fourteen-bit multiplier. A change of request level in the other direction while a step is open abandons that step and starts a new one. The new step uses its own mask and code.

Top module: `rail_enable_sequencer`

## Requirements
- R1: The time code is decoded as follows. Bits 15:14 select the increment: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 512 millisecond ticks. Bits 13:0 hold the multiplier. The deadline is reached after exactly increment × multiplier ticks, counted from the cycle after the request is captured.
- R2: A multiplier of 0 gives an immediate deadline, whatever the increment selector holds.
- R3: A rise of the request level opens an on step. `rail_en` goes to 1 once every `gpo_state` bit whose `on_mask` bit is 1 reads 1. Bit n of a mask selects `gpo_state[n]`, and unselected bits are ignored. When the conditions already hold, `rail_en` changes on the second clock edge after the request edge is sampled.
- R4: A fall of the request level opens an off step. `rail_en` goes to 0 once every `gpo_state` bit whose `off_mask` bit is 1 reads 0.
- R5: Once a step has completed, later changes of `gpo_state` do not move `rail_en`.
- R6: In normal mode, an expired deadline with the conditions unmet ends the step. `seq_timeout` is set, `rail_en` keeps its value, and the flag holds until the next request edge clears it. When the conditions are met in the same cycle the deadline expires, the conditions win.
- R7: With `dbg_mode` high, the conditions are ignored. The rail takes the requested value when the deadline expires, and `seq_timeout` stays 0.
- R8: With `dbg_mode` high and a zero deadline, the rail switches on the first open cycle, so `seq_busy` is high for one cycle.
- R9: A request edge in the opposite direction while a step is open abandons that step. It restarts the deadline from the new direction's code and applies the new direction's mask.
- R10: `seq_busy` is high from the cycle after a request edge is captured until the step completes or times out. `rail_en` changes only at the end of a busy period.
- R11: After reset, `rail_en`, `seq_busy` and `seq_timeout` are 0, and the request level is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| seq_req | input | 1 | Requested rail level; each edge opens a step |
| gpo_state | input | 8 | Logical output states used as conditions |
| on_mask | input | 8 | Condition select for on steps |
| off_mask | input | 8 | Condition select for off steps |
| on_code | input | 16 | Deadline code for on steps |
| off_code | input | 16 | Deadline code for off steps |
| dbg_mode | input | 1 | Bypass conditions; switch at deadline |
| rail_en | output | 1 | Rail enable |
| seq_busy | output | 1 | A step is open |
| seq_timeout | output | 1 | Last step timed out |

## Verification
The bench counts the ticks spent in each busy period against every increment selector. This catches a decoder with swapped or shifted increments, and a counter that is off by one tick. Zero multipliers are checked under a non-zero selector, in both normal and debug mode: a timer that waits one full increment, or a debug path that still honours the masks, gives the wrong tick or busy-cycle count. An opposite request in the middle of a step must restart the deadline with the other code and mask. A design that kept the first timer would report the wrong tick count, and one that kept the first mask would move the enable. After completion, and while the timeout flag is held, the bench moves the GPO states to expose a block that keeps watching its conditions or clears the flag too early.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SEL_W = 2;
  localparam int PRE_W = 1 + 3 * ((1 << SEL_W) - 1);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } seq_state_e;

  function automatic logic [PRE_W-1:0] inc_ticks(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] one;
    one = {{(PRE_W-1){1'b0}}, 1'b1};
    return one << (3 * sel);
  endfunction
endpackage

// File: rtl/seq_code_timer.sv
module seq_code_timer
  import seq_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int MULT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              tick,
  output logic              expired
);
  logic [MULT_W-1:0] mult_q, mult_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [PRE_W-1:0]  inc_q, inc_d;
  logic              mult_zero;

  assign mult_zero = (mult_q == '0);
  assign expired   = mult_zero;

  always_comb begin
    mult_d = mult_q;
    pre_d  = pre_q;
    inc_d  = inc_q;
    if (start) begin
      mult_d = code[MULT_W-1:0];
      inc_d  = inc_ticks(code[CODE_W-1 -: SEL_W]);
      pre_d  = inc_d;
    end else if (tick && !mult_zero) begin
      if (pre_q == {{(PRE_W-1){1'b0}}, 1'b1}) begin
        mult_d = mult_q - 1'b1;
        pre_d  = inc_q;
      end else begin
        pre_d = pre_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      pre_q  <= '0;
      inc_q  <= '0;
    end else begin
      mult_q <= mult_d;
      pre_q  <= pre_d;
      inc_q  <= inc_d;
    end
  end

  // R2: a zero multiplier expires on the first open cycle
  a_r2_zero_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (start && code[MULT_W-1:0] == '0) |=> expired);

  // R1: once expired, stays expired until restarted
  a_r1_expiry_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && expired) |=> expired);

  // R1: the multiplier only moves on a tick or a restart
  a_r1_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> $stable(mult_q));
endmodule

// File: rtl/seq_dep_gate.sv
module seq_dep_gate #(
  parameter int GPO_W = 8
) (
  input  logic [GPO_W-1:0] gpo_state,
  input  logic [GPO_W-1:0] on_mask,
  input  logic [GPO_W-1:0] off_mask,
  output logic             on_ok,
  output logic             off_ok
);
  logic [GPO_W-1:0] on_bit;
  logic [GPO_W-1:0] off_bit;

  for (genvar i = 0; i < GPO_W; i++) begin : g_bit
    assign on_bit[i]  = !on_mask[i]  || gpo_state[i];
    assign off_bit[i] = !off_mask[i] || !gpo_state[i];
  end

  assign on_ok  = &on_bit;
  assign off_ok = &off_bit;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seq_req,
  input  logic on_ok,
  input  logic off_ok,
  input  logic expired,
  input  logic dbg_mode,
  output logic start,
  output logic rail_en,
  output logic seq_busy,
  output logic seq_timeout
);
  seq_state_e state_q, state_d;
  logic req_q;
  logic dir_q, dir_d;
  logic en_q, en_d;
  logic to_q, to_d;
  logic req_edge;
  logic cond_ok;
  logic go;

  assign req_edge = (seq_req != req_q);
  assign start    = req_edge;
  assign cond_ok  = dir_q ? on_ok : off_ok;
  assign go       = dbg_mode ? expired : cond_ok;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    en_d    = en_q;
    to_d    = to_q;
    if (req_edge) begin
      state_d = ST_PEND;
      dir_d   = seq_req;
      to_d    = 1'b0;
    end else if (state_q == ST_PEND) begin
      if (go) begin
        en_d    = dir_q;
        state_d = ST_IDLE;
      end else if (expired) begin
        to_d    = 1'b1;
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      dir_q   <= 1'b0;
      en_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= seq_req;
      dir_q   <= dir_d;
      en_q    <= en_d;
      to_q    <= to_d;
    end
  end

  assign rail_en     = en_q;
  assign seq_busy    = (state_q == ST_PEND);
  assign seq_timeout = to_q;

  // R5: no enable movement while idle without a new request
  a_r5_idle_holds_en: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !req_edge) |=> $stable(rail_en));

  // R6: a timeout never comes with an enable change
  a_r6_timeout_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_timeout) |-> $stable(rail_en));

  // R7: debug mode never raises the timeout flag
  a_r7_dbg_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && dbg_mode && !req_edge) |=> !seq_timeout);

  // R9: a request edge always opens a fresh step with a clear flag
  a_r9_edge_opens: assert property (@(posedge clk) disable iff (!rst_n)
    req_edge |=> (seq_busy && !seq_timeout));

  // R10: the enable only moves at the end of a busy period
  a_r10_move_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en != $past(rail_en)) |-> $past(seq_busy));
endmodule

// File: rtl/rail_enable_sequencer.sv
module rail_enable_sequencer
  import seq_pkg::*;
#(
  parameter int GPO_W  = 8,
  parameter int CODE_W = 16,
  parameter int MULT_W = CODE_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              seq_req,
  input  logic [GPO_W-1:0]  gpo_state,
  input  logic [GPO_W-1:0]  on_mask,
  input  logic [GPO_W-1:0]  off_mask,
  input  logic [CODE_W-1:0] on_code,
  input  logic [CODE_W-1:0] off_code,
  input  logic              dbg_mode,
  output logic              rail_en,
  output logic              seq_busy,
  output logic              seq_timeout
);
  logic              on_ok;
  logic              off_ok;
  logic              expired;
  logic              start;
  logic [CODE_W-1:0] sel_code;

  // the level being requested names the direction of a new step
  assign sel_code = seq_req ? on_code : off_code;

  seq_dep_gate #(.GPO_W(GPO_W)) u_gate (
    .gpo_state (gpo_state),
    .on_mask   (on_mask),
    .off_mask  (off_mask),
    .on_ok     (on_ok),
    .off_ok    (off_ok)
  );

  seq_code_timer #(.CODE_W(CODE_W), .MULT_W(MULT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .code    (sel_code),
    .tick    (ms_tick),
    .expired (expired)
  );

  seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_req     (seq_req),
    .on_ok       (on_ok),
    .off_ok      (off_ok),
    .expired     (expired),
    .dbg_mode    (dbg_mode),
    .start       (start),
    .rail_en     (rail_en),
    .seq_busy    (seq_busy),
    .seq_timeout (seq_timeout)
  );
endmodule

// File: tb/rail_enable_sequencer_bench.sv
module rail_enable_sequencer_bench;
  logic        clk;
  logic        rst_n;
  logic        ms_tick;
  logic        seq_req;
  logic [7:0]  gpo_state;
  logic [7:0]  on_mask;
  logic [7:0]  off_mask;
  logic [15:0] on_code;
  logic [15:0] off_code;
  logic        dbg_mode;
  logic        rail_en;
  logic        seq_busy;
  logic        seq_timeout;

  int checks = 0;
  int errors = 0;
  bit tick_run = 0;
  bit done = 0;

  typedef struct {
    logic  en;
    logic  to;
    int    ticks;
    int    cycles;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  rail_enable_sequencer u_rail_enable_sequencer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .seq_req(seq_req),
    .gpo_state(gpo_state), .on_mask(on_mask), .off_mask(off_mask),
    .on_code(on_code), .off_code(off_code), .dbg_mode(dbg_mode),
    .rail_en(rail_en), .seq_busy(seq_busy), .seq_timeout(seq_timeout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // millisecond strobe: one cycle in four
  initial begin
    ms_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (tick_run) begin
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
  end

  // monitor: samples 1 ns after each rising edge
  int  tick_cnt = 0;
  int  busy_cyc = 0;
  logic busy_last = 1'b0;
  logic req_last = 1'b0;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      tick_cnt = 0; busy_cyc = 0; busy_last = 1'b0; req_last = 1'b0;
    end else begin
      if (seq_req != req_last) begin
        tick_cnt = 0; busy_cyc = 0;
      end else if (busy_last && ms_tick) begin
        tick_cnt++;
      end
      if (seq_busy) busy_cyc++;
      if (busy_last && !seq_busy) begin
        if (exp_q.size() == 0) begin
          check("unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " rail_en"}, rail_en, e.en);
          check({e.tag, " seq_timeout"}, seq_timeout, e.to);
          if (e.ticks >= 0) check({e.tag, " ticks"}, tick_cnt, e.ticks);
          if (e.cycles >= 0) check({e.tag, " busy cycles"}, busy_cyc, e.cycles);
        end
      end
      busy_last = seq_busy;
      req_last  = seq_req;
    end
  end

  task automatic issue(input logic lvl, input logic en, input logic to,
                       input int ticks, input int cycles, input string tag);
    exp_t e;
    e.en = en; e.to = to; e.ticks = ticks; e.cycles = cycles; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    seq_req = lvl;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [1:0] sel, input int m);
    return {sel, m[13:0]};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; seq_req = 1'b0; gpo_state = '0; on_mask = '0; off_mask = '0;
    on_code = '0; off_code = '0; dbg_mode = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 reset rail_en", rail_en, 0);
    check("R11 reset seq_busy", seq_busy, 0);
    check("R11 reset seq_timeout", seq_timeout, 0);
    rst_n = 1'b1;
    tick_run = 1;
    repeat (3) @(negedge clk);

    // R3: conditions already met, one busy cycle
    on_mask = 8'h03; gpo_state = 8'h03; on_code = mk(2'b00, 5);
    issue(1'b1, 1'b1, 1'b0, -1, 1, "R3 on met");
    wait_done();

    // R5: conditions move after completion
    gpo_state = 8'h00;
    repeat (10) @(negedge clk);
    check("R5 en after gpo change", rail_en, 1);

    // R4: off step waits for selected bits to read 0
    off_mask = 8'hF0; gpo_state = 8'h10; off_code = mk(2'b00, 200);
    issue(1'b0, 1'b0, 1'b0, -1, -1, "R4 off");
    repeat (8) @(negedge clk);
    check("R4 en held while waiting", rail_en, 1);
    check("R10 busy while waiting", seq_busy, 1);
    gpo_state = 8'h0F;
    wait_done();

    // R3: on step waits; unselected bits ignored
    on_mask = 8'h0C; gpo_state = 8'h04; on_code = mk(2'b00, 200);
    issue(1'b1, 1'b1, 1'b0, -1, -1, "R3 on wait");
    repeat (8) @(negedge clk);
    check("R3 en held while waiting", rail_en, 0);
    gpo_state = 8'h3C;
    wait_done();

    // R6 + R1: normal timeout, increment 1
    off_mask = 8'h01; gpo_state = 8'h01; off_code = mk(2'b00, 5);
    issue(1'b0, 1'b1, 1'b1, 5, -1, "R6 R1 timeout inc1");
    wait_done();
    gpo_state = 8'h00;
    repeat (10) @(negedge clk);
    check("R6 flag held", seq_timeout, 1);
    check("R6 en kept", rail_en, 1);

    // R6: next request clears the flag
    on_mask = 8'h00; on_code = mk(2'b00, 3);
    issue(1'b1, 1'b1, 1'b0, -1, 1, "R6 clear on request");
    wait_done();

    // R1: increment 8
    off_mask = 8'h01; gpo_state = 8'h01; off_code = mk(2'b01, 2);
    issue(1'b0, 1'b1, 1'b1, 16, -1, "R1 inc8");
    wait_done();

    // R1: increment 64
    on_mask = 8'h80; on_code = mk(2'b10, 1);
    issue(1'b1, 1'b1, 1'b1, 64, -1, "R1 inc64");
    wait_done();

    // R1: increment 512
    off_code = mk(2'b11, 1);
    issue(1'b0, 1'b1, 1'b1, 512, -1, "R1 inc512");
    wait_done();

    // R2: zero multiplier with the largest increment
    on_code = mk(2'b11, 0);
    issue(1'b1, 1'b1, 1'b1, 0, 1, "R2 zero mult");
    wait_done();

    // R7: debug switches at the deadline, conditions unmet
    dbg_mode = 1'b1; off_code = mk(2'b00, 3);
    issue(1'b0, 1'b0, 1'b0, 3, -1, "R7 debug off");
    wait_done();

    // R8: debug with a zero deadline
    on_code = mk(2'b10, 0);
    issue(1'b1, 1'b1, 1'b0, 0, 1, "R8 debug zero");
    wait_done();
    dbg_mode = 1'b0;

    // R9: abort an off step by an on request, new code and mask apply
    off_mask = 8'h01; gpo_state = 8'h01; off_code = mk(2'b00, 100);
    @(negedge clk); seq_req = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 pending off busy", seq_busy, 1);
    on_mask = 8'h02; on_code = mk(2'b00, 4);
    issue(1'b1, 1'b1, 1'b1, 4, -1, "R9 abort restart");
    wait_done();

    // R9: abort an on step by an off request that completes
    off_mask = 8'h00;
    issue(1'b0, 1'b0, 1'b0, -1, 1, "R9 prep off");
    wait_done();
    on_mask = 8'h02; gpo_state = 8'h01; on_code = mk(2'b00, 100);
    @(negedge clk); seq_req = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 on pending en", rail_en, 0);
    issue(1'b0, 1'b0, 1'b0, -1, 1, "R9 abort to off");
    wait_done();
    check("R9 no stray on", rail_en, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule